// File: doc/BRIEF.md
# USB Root Port Status and Control Register

This block holds the 16-bit status/control word of each downstream port of a USB root hub. It reacts to device attach and detach events, records the device speed, and keeps connect and enable state together with sticky change flags that a driver polls. Register writes update only the bits that software owns. The bits that hardware owns keep their value through a write.

A write that raises the port-reset bit sends a single-cycle reset pulse to the device on that port, if one is connected. Every attach or detach produces a one-cycle resume event toward the controller, so a suspended controller can wake up. The register offset selects the port. An offset that names a port beyond the configured count is ignored on write and reads back all ones. A per-port qualifier tells the traffic path when the port may carry device packets.

Top module: `usb_root_port_regs`

## Requirements
- R1: After reset every port word reads 0x0080, and `port_reset` and `resume_evt` are low.
- R2: An attach sets bit 0 (connected) and bit 1 (connect changed). It sets bit 8 (low speed) to the value of `low_speed` and clears bit 8 otherwise.
- R3: A detach on a connected port clears bit 0 and sets bit 1. A detach on an unconnected port leaves bits 0 and 1 as they were.
- R4: A detach on a port with bit 2 (enabled) set clears bit 2 and sets bit 3 (enable changed).
- R5: `resume_evt` is high for exactly the cycle after any attach or detach on any port.
- R6: A write whose data has bit 9 (port reset) at 1 raises `port_reset` for that port for the one following cycle, but only when the stored bit 9 is 0 and the port is connected.
- R7: A write sets the word to (old AND 0x01FB) OR (data AND NOT 0x01FB).
- R8: The port index is `addr[3:1]`. An index of `NUM_PORTS` or above changes no port on write and reads 0xFFFF.
- R9: `traffic_ok` for a port is high exactly when bits 0 and 2 of its word are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| attach | input | NUM_PORTS | One-cycle device attach event per port |
| detach | input | NUM_PORTS | One-cycle device detach event per port |
| low_speed | input | NUM_PORTS | Speed of the attaching device, 1 = low speed |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register offset for reads and writes |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr`, combinational |
| port_reset | output | NUM_PORTS | One-cycle reset pulse toward each device |
| resume_evt | output | 1 | One-cycle resume request to the controller |
| traffic_ok | output | NUM_PORTS | Port may pass device traffic |

## Verification
The assertions check several rules on every cycle: attach and detach effects on the connect, change and enable bits, the preservation of hardware-owned bits across a plain write, the single-cycle shape of the reset pulse, the resume event after each event, and the fact that out-of-range writes leave every port unchanged. Only the bench scenarios show the exact read-back values of each offset, the gating of the reset pulse by the stored reset bit and by connection, and the traffic qualifier across sequences of attach, write and detach on both ports.

// File: rtl/usb_port_pkg.sv
// Package: shared constants for the root port status word.
// Assumes a 16-bit word; bit positions are fixed by the register layout.
package usb_port_pkg;
    localparam int unsigned WORD_W      = 16;
    localparam int unsigned B_CONN      = 0;
    localparam int unsigned B_CONN_CHG  = 1;
    localparam int unsigned B_EN        = 2;
    localparam int unsigned B_EN_CHG    = 3;
    localparam int unsigned B_LOWSPD    = 8;
    localparam int unsigned B_PRST      = 9;
    localparam logic [WORD_W-1:0] HW_KEEP_MASK = 16'h01FB;
    localparam logic [WORD_W-1:0] WORD_INIT    = 16'h0080;

    typedef logic [WORD_W-1:0] port_word_t;

    // Merge write data into the software-owned bits only.
    function automatic port_word_t merge_write(port_word_t old_w, port_word_t data_w);
        return (old_w & HW_KEEP_MASK) | (data_w & ~HW_KEEP_MASK);
    endfunction
endpackage

// File: rtl/port_addr_decode.sv
// Module: port_addr_decode
// Turns a register offset into a port index, a valid flag and one-hot
// write selects. Assumes offset bit 0 is a byte lane and plays no part.
module port_addr_decode #(
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned ADDR_W    = 4,
    localparam int unsigned IDX_W    = ADDR_W - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    output logic [IDX_W-1:0]     idx,
    output logic                 idx_ok,
    output logic [NUM_PORTS-1:0] wr_sel
);
    // Extract index and range check.
    always_comb begin
        idx    = addr[ADDR_W-1:1];
        idx_ok = ({1'b0, idx} < (IDX_W+1)'(NUM_PORTS));
    end

    // One write select per port.
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_sel
        assign wr_sel[g] = wr_en && idx_ok && (idx == IDX_W'(g));
    end

    // R8
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));
endmodule

// File: rtl/port_status_reg.sv
// Module: port_status_reg
// One port's status/control word: merges writes, applies attach/detach
// events and issues a reset pulse on a rising reset bit. Assumes an event
// in the same cycle as a write is applied on top of the written value,
// and attach wins over detach.
module port_status_reg
    import usb_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  port_word_t wr_data,
    input  logic       attach,
    input  logic       detach,
    input  logic       low_speed,
    output port_word_t status,
    output logic       reset_pulse
);
    port_word_t nxt;
    logic       pulse_d;

    // Next word: write merge first, then device events.
    always_comb begin
        nxt = status;
        if (wr_hit) nxt = merge_write(status, wr_data);
        if (attach) begin
            nxt[B_CONN]     = 1'b1;
            nxt[B_CONN_CHG] = 1'b1;
            nxt[B_LOWSPD]   = low_speed;
        end else if (detach) begin
            if (nxt[B_CONN]) begin
                nxt[B_CONN]     = 1'b0;
                nxt[B_CONN_CHG] = 1'b1;
            end
            if (nxt[B_EN]) begin
                nxt[B_EN]     = 1'b0;
                nxt[B_EN_CHG] = 1'b1;
            end
        end
    end

    // Reset pulse request: rising reset bit on a connected port.
    always_comb pulse_d = wr_hit && wr_data[B_PRST] && !status[B_PRST] && status[B_CONN];

    // Register the word and the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status      <= WORD_INIT;
            reset_pulse <= 1'b0;
        end else begin
            status      <= nxt;
            reset_pulse <= pulse_d;
        end
    end

    // R2
    attach_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        attach |=> status[B_CONN] && status[B_CONN_CHG] && (status[B_LOWSPD] == $past(low_speed)));
    // R3
    detach_conn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (detach && !attach && !wr_hit && status[B_CONN]) |=> !status[B_CONN] && status[B_CONN_CHG]);
    // R4
    detach_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (detach && !attach && !wr_hit && status[B_EN]) |=> !status[B_EN] && status[B_EN_CHG]);
    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |=> !reset_pulse);
    // R7
    keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !attach && !detach) |=> (((status ^ $past(status)) & HW_KEEP_MASK) == '0));
endmodule

// File: rtl/usb_root_port_regs.sv
// Module: usb_root_port_regs (top)
// Bank of root port status words with offset decode, read mux, resume
// event and traffic qualifiers. Assumes one-cycle attach/detach events.
module usb_root_port_regs
    import usb_port_pkg::*;
#(
    parameter int unsigned NUM_PORTS  = 2,
    parameter int unsigned ADDR_W     = 4,
    parameter logic [15:0] DEFAULT_RD = 16'hFFFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] attach,
    input  logic [NUM_PORTS-1:0] detach,
    input  logic [NUM_PORTS-1:0] low_speed,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [15:0]          wr_data,
    output logic [15:0]          rd_data,
    output logic [NUM_PORTS-1:0] port_reset,
    output logic                 resume_evt,
    output logic [NUM_PORTS-1:0] traffic_ok
);
    localparam int unsigned IDX_W = ADDR_W - 1;

    logic [IDX_W-1:0]                idx;
    logic                            idx_ok;
    logic [NUM_PORTS-1:0]            wr_sel;
    logic [NUM_PORTS-1:0][WORD_W-1:0] words;

    port_addr_decode #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .idx(idx), .idx_ok(idx_ok), .wr_sel(wr_sel)
    );

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        port_status_reg u_reg (
            .clk(clk), .rst_n(rst_n), .wr_hit(wr_sel[g]), .wr_data(wr_data),
            .attach(attach[g]), .detach(detach[g]), .low_speed(low_speed[g]),
            .status(words[g]), .reset_pulse(port_reset[g])
        );
        // Traffic allowed only when connected and enabled.
        assign traffic_ok[g] = words[g][B_CONN] && words[g][B_EN];
    end

    // Read mux with default for out-of-range ports.
    always_comb begin
        rd_data = DEFAULT_RD;
        for (int i = 0; i < NUM_PORTS; i++)
            if (idx_ok && idx == IDX_W'(i)) rd_data = words[i];
    end

    // Resume request after any connect event.
    always_ff @(posedge clk) begin
        if (!rst_n) resume_evt <= 1'b0;
        else        resume_evt <= |attach || |detach;
    end

    // R5
    resume_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|attach || |detach) |=> resume_evt);
    // R8
    bad_port_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !idx_ok && attach == '0 && detach == '0) |=> $stable(words));
endmodule

// File: tb/usb_root_port_regs_tb.sv
module usb_root_port_regs_tb;
    localparam int NP = 2;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] attach = '0, detach = '0, low_speed = '0;
    logic wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [NP-1:0] port_reset, traffic_ok;
    logic resume_evt;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_w [NP];

    always #5 clk = ~clk;

    usb_root_port_regs #(.NUM_PORTS(NP), .ADDR_W(4), .DEFAULT_RD(16'hFFFF)) u_dut (
        .clk(clk), .rst_n(rst_n), .attach(attach), .detach(detach),
        .low_speed(low_speed), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .port_reset(port_reset), .resume_evt(resume_evt),
        .traffic_ok(traffic_ok)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Read every offset and compare with the model (R8 decode, R9 qualifier).
    task automatic check_all(string req);
        for (int o = 0; o < 16; o++) begin
            automatic int ix = o >> 1;
            addr = 4'(o);
            #1;
            chk(req, rd_data, (ix < NP) ? exp_w[ix] : 16'hFFFF);
        end
        for (int p = 0; p < NP; p++)
            chk("R9", 16'(traffic_ok[p]), 16'(exp_w[p][0] & exp_w[p][2]));
    endtask

    task automatic do_write(logic [3:0] a, logic [15:0] d);
        automatic int ix = a >> 1;
        automatic logic [NP-1:0] pexp = '0;
        if (ix < NP) begin
            pexp[ix] = d[9] && !exp_w[ix][9] && exp_w[ix][0];
            exp_w[ix] = (exp_w[ix] & 16'h01FB) | (d & ~16'h01FB);
        end
        @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
        chk("R6", 16'(port_reset), 16'(pexp));
        @(negedge clk);
        chk("R6", 16'(port_reset), 16'h0);
        check_all("R7");
    endtask

    task automatic do_event(int p, bit is_attach, bit ls);
        if (is_attach) begin
            exp_w[p][0] = 1'b1; exp_w[p][1] = 1'b1; exp_w[p][8] = ls;
        end else begin
            if (exp_w[p][0]) begin exp_w[p][0] = 1'b0; exp_w[p][1] = 1'b1; end
            if (exp_w[p][2]) begin exp_w[p][2] = 1'b0; exp_w[p][3] = 1'b1; end
        end
        @(negedge clk);
        if (is_attach) begin attach[p] = 1'b1; low_speed[p] = ls; end
        else detach[p] = 1'b1;
        @(negedge clk); attach = '0; detach = '0;
        chk("R5", 16'(resume_evt), 16'h1);
        @(negedge clk);
        chk("R5", 16'(resume_evt), 16'h0);
        check_all(is_attach ? "R2" : "R3/R4");
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) exp_w[p] = 16'h0080;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", 16'(port_reset), 16'h0);
        chk("R1", 16'(resume_evt), 16'h0);
        check_all("R1");
        // R6: reset bit on an unconnected port gives no pulse
        do_write(4'd0, 16'h0200);
        do_write(4'd0, 16'h0000);
        for (int p = 0; p < NP; p++) begin
            automatic logic [3:0] a = 4'(p << 1);
            do_event(p, 1'b1, p[0]);              // R2
            do_event(p, 1'b1, !p[0]);             // R2 speed change
            do_write(a, 16'hFFFF);                // R7, R6 pulse
            do_write(a | 4'd1, 16'hFFFF);         // R6 no second pulse, odd offset R8
            do_write(a, 16'h0000);
            do_write(a, 16'hA5A5);                // R7 pattern
            do_write(a, 16'h0004);                // R9 enable
            do_write(a, 16'h0204);                // R6 pulse again
            do_event(p, 1'b0, 1'b0);              // R3, R4
            do_event(p, 1'b0, 1'b0);              // R3 unconnected detach
            do_write(a, 16'h0200);                // R6 disconnected: no pulse
            do_write(a, 16'h0004);
        end
        // R8: out-of-range writes change nothing and read default
        do_event(0, 1'b1, 1'b0);
        for (int o = 2*NP; o < 16; o++) do_write(4'(o), 16'hFFFF);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule